// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block is a legacy-style configuration space for a small I/O controller. A host reaches it through two byte-wide ports on an 8-bit I/O bus. It writes a register number to the index port, then reads or writes that register through the data port. The space is guarded by a key sequence. Two back-to-back index writes of 0xA5 open it. An index write of 0xAA closes it again.

Register 0x07 holds a logical-device number. Registers 0x30 and above are banked: they reach the per-device storage of whichever device that number selects. Each device has an enable bit, a 16-bit I/O base, an interrupt number and an interrupt type. These values are driven out on flat vectors so that the configured devices can use them. Device numbers are parameters. By default there are two devices: slot 0 answers to number 0x02 and slot 1 answers to number 0x0D.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is closed (`cfgOpen`=0). All device outputs are zero, and the selected register and device number are 0x00.
- R2: Two consecutive index-port writes of 0xA5 open the space. Any other index-port value written between them restarts the sequence, so the space stays closed.
- R3: While closed, data-port writes change nothing, and any port read returns 0xFF.
- R4: While open, an index-port write of 0xAA closes the space on the next cycle.
- R5: While open, every other index-port value becomes the selected register and reads back from the index port (`portSel`=0). The space stays open across any number of accesses.
- R6: Register 0x07 holds the logical-device number. A data write to it stores the byte, and a data read returns it.
- R7: For the selected device, register 0x30 bit 0 is the enable, which reads back as 0x00 or 0x01. Register 0x60 is the I/O base high byte and 0x61 the low byte. Register 0x70 is the interrupt number and 0x71 the interrupt type (0x01 means active-low level). Each value appears on the device's output slice (slot k at bits [16k+15:16k] or [8k+7:8k]) one cycle after the write.
- R8: A banked write changes only the device whose number matches register 0x07. A banked read returns that device's value.
- R9: When register 0x07 holds a number that no device answers to, banked reads return 0x00 and banked writes change no output.
- R10: Register numbers other than 0x07, 0x30, 0x60, 0x61, 0x70 and 0x71 read as 0x00 while open, and writes to them have no effect.
- R11: `rdData` is 0x00 whenever `ioRd` is low. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | Write strobe, one access per cycle |
| ioRd | input | 1 | Read strobe |
| portSel | input | 1 | 0 selects the index port, 1 the data port |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, combinational from state and port select |
| cfgOpen | output | 1 | Configuration space is unlocked |
| devEnable | output | NUM_DEV | Enable bit per device slot |
| devIoBase | output | 16*NUM_DEV | I/O base per device slot |
| devIrqNum | output | 8*NUM_DEV | Interrupt number per device slot |
| devIrqType | output | 8*NUM_DEV | Interrupt type per device slot |

## Verification
The assertions check, on every cycle, these properties: a closed space answers reads with 0xFF and ignores data writes; the lock value closes the space; the space opens only right after an index write of 0xA5; and an idle read strobe gives zero. Other behaviour needs the bench's scenarios, run against its reference model: an interrupted key sequence, banking between the two device numbers, an unknown device number, undefined registers, and the 0x30 enable masking.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int BYTE_W = 8;

  localparam logic [7:0] KEY_OPEN  = 8'hA5;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ENABLE  = 8'h30;
  localparam logic [7:0] REG_BASE_HI = 8'h60;
  localparam logic [7:0] REG_BASE_LO = 8'h61;
  localparam logic [7:0] REG_IRQ_NUM = 8'h70;
  localparam logic [7:0] REG_IRQ_TYP = 8'h71;

  typedef enum logic [1:0] {
    LK_SHUT,
    LK_HALF,
    LK_OPEN
  } lockState_t;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_ALLF,
    RD_INDEX,
    RD_LDN,
    RD_EN,
    RD_BHI,
    RD_BLO,
    RD_IRQ,
    RD_TYPE,
    RD_ZERO
  } readSel_t;

  typedef struct packed {
    logic ldnWr;
    logic enWr;
    logic baseHiWr;
    logic baseLoWr;
    logic irqNumWr;
    logic irqTypeWr;
  } cfgStrobe_t;

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter logic [NUM_DEV*8-1:0] DEV_IDS = 16'h0D02
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ioWr,
  input  logic               ioRd,
  input  logic               portSel,
  input  logic [BYTE_W-1:0]  wrData,
  output cfgStrobe_t         strobe,
  output logic [NUM_DEV-1:0] devHit,
  output readSel_t           rdSel,
  output logic               open,
  output logic [BYTE_W-1:0]  indexReg,
  output logic [BYTE_W-1:0]  ldnReg
);

  lockState_t lockState, lockNext;
  logic idxWr, datWr;

  assign idxWr = ioWr && !portSel;
  assign datWr = ioWr && portSel;
  assign open  = (lockState == LK_OPEN);

  always_comb begin
    lockNext = lockState;
    unique case (lockState)
      LK_SHUT: if (idxWr && wrData == KEY_OPEN) lockNext = LK_HALF;
      LK_HALF: if (idxWr) lockNext = (wrData == KEY_OPEN) ? LK_OPEN : LK_SHUT;
      LK_OPEN: if (idxWr && wrData == KEY_CLOSE) lockNext = LK_SHUT;
      default: lockNext = LK_SHUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockState <= LK_SHUT;
      indexReg  <= '0;
      ldnReg    <= '0;
    end else begin
      lockState <= lockNext;
      if (open && idxWr && wrData != KEY_CLOSE) indexReg <= wrData;
      if (strobe.ldnWr) ldnReg <= wrData;
    end
  end

  // write strobes toward the datapath
  always_comb begin
    strobe = '0;
    if (open && datWr) begin
      strobe.ldnWr     = (indexReg == REG_LDN);
      strobe.enWr      = (indexReg == REG_ENABLE);
      strobe.baseHiWr  = (indexReg == REG_BASE_HI);
      strobe.baseLoWr  = (indexReg == REG_BASE_LO);
      strobe.irqNumWr  = (indexReg == REG_IRQ_NUM);
      strobe.irqTypeWr = (indexReg == REG_IRQ_TYP);
    end
  end

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_hit
    assign devHit[k] = (ldnReg == DEV_IDS[k*8 +: 8]);
  end

  // read source selection
  always_comb begin
    if (!ioRd)          rdSel = RD_NONE;
    else if (!open)     rdSel = RD_ALLF;
    else if (!portSel)  rdSel = RD_INDEX;
    else begin
      unique case (indexReg)
        REG_LDN:     rdSel = RD_LDN;
        REG_ENABLE:  rdSel = RD_EN;
        REG_BASE_HI: rdSel = RD_BHI;
        REG_BASE_LO: rdSel = RD_BLO;
        REG_IRQ_NUM: rdSel = RD_IRQ;
        REG_IRQ_TYP: rdSel = RD_TYPE;
        default:     rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cfgStrobe_t             strobe,
  input  logic [NUM_DEV-1:0]     devHit,
  input  readSel_t               rdSel,
  input  logic [BYTE_W-1:0]      wrData,
  input  logic [BYTE_W-1:0]      indexReg,
  input  logic [BYTE_W-1:0]      ldnReg,
  output logic [BYTE_W-1:0]      rdData,
  output logic [NUM_DEV-1:0]     devEnable,
  output logic [NUM_DEV*16-1:0]  devIoBase,
  output logic [NUM_DEV*8-1:0]   devIrqNum,
  output logic [NUM_DEV*8-1:0]   devIrqType
);

  logic [BYTE_W-1:0] devByte [NUM_DEV];

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
    logic              enReg;
    logic [BYTE_W-1:0] baseHi, baseLo, irqNum, irqType;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enReg   <= 1'b0;
        baseHi  <= '0;
        baseLo  <= '0;
        irqNum  <= '0;
        irqType <= '0;
      end else if (devHit[k]) begin
        if (strobe.enWr)      enReg   <= wrData[0];
        if (strobe.baseHiWr)  baseHi  <= wrData;
        if (strobe.baseLoWr)  baseLo  <= wrData;
        if (strobe.irqNumWr)  irqNum  <= wrData;
        if (strobe.irqTypeWr) irqType <= wrData;
      end
    end

    always_comb begin
      unique case (rdSel)
        RD_EN:   devByte[k] = {7'd0, enReg};
        RD_BHI:  devByte[k] = baseHi;
        RD_BLO:  devByte[k] = baseLo;
        RD_IRQ:  devByte[k] = irqNum;
        RD_TYPE: devByte[k] = irqType;
        default: devByte[k] = '0;
      endcase
    end

    assign devEnable[k]            = enReg;
    assign devIoBase[k*16 +: 16]   = {baseHi, baseLo};
    assign devIrqNum[k*8 +: 8]     = irqNum;
    assign devIrqType[k*8 +: 8]    = irqType;
  end

  always_comb begin
    logic [BYTE_W-1:0] bankOr;
    bankOr = '0;
    for (int k = 0; k < NUM_DEV; k++) begin
      if (devHit[k]) bankOr = bankOr | devByte[k];
    end
    unique case (rdSel)
      RD_NONE:  rdData = '0;
      RD_ALLF:  rdData = '1;
      RD_INDEX: rdData = indexReg;
      RD_LDN:   rdData = ldnReg;
      RD_ZERO:  rdData = '0;
      default:  rdData = bankOr;
    endcase
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter logic [NUM_DEV*8-1:0] DEV_IDS = 16'h0D02
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ioWr,
  input  logic                  ioRd,
  input  logic                  portSel,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  output logic                  cfgOpen,
  output logic [NUM_DEV-1:0]    devEnable,
  output logic [NUM_DEV*16-1:0] devIoBase,
  output logic [NUM_DEV*8-1:0]  devIrqNum,
  output logic [NUM_DEV*8-1:0]  devIrqType
);

  cfgStrobe_t         strobe;
  logic [NUM_DEV-1:0] devHit;
  readSel_t           rdSel;
  logic [7:0]         indexReg, ldnReg;

  sio_cfg_ctrl #(.NUM_DEV(NUM_DEV), .DEV_IDS(DEV_IDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .portSel(portSel),
    .wrData(wrData), .strobe(strobe), .devHit(devHit), .rdSel(rdSel),
    .open(cfgOpen), .indexReg(indexReg), .ldnReg(ldnReg)
  );

  sio_cfg_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .devHit(devHit), .rdSel(rdSel),
    .wrData(wrData), .indexReg(indexReg), .ldnReg(ldnReg), .rdData(rdData),
    .devEnable(devEnable), .devIoBase(devIoBase), .devIrqNum(devIrqNum),
    .devIrqType(devIrqType)
  );

endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk #(
  parameter int NUM_DEV = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  ioWr,
  input logic                  ioRd,
  input logic                  portSel,
  input logic [7:0]            wrData,
  input logic [7:0]            rdData,
  input logic                  cfgOpen,
  input logic [NUM_DEV-1:0]    devEnable,
  input logic [NUM_DEV*16-1:0] devIoBase,
  input logic [NUM_DEV*8-1:0]  devIrqNum,
  input logic [NUM_DEV*8-1:0]  devIrqType
);

  // R3
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgOpen && ioRd) |-> rdData == 8'hFF);

  // R3
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgOpen && ioWr && portSel) |=>
      ($stable(devEnable) && $stable(devIoBase) && $stable(devIrqNum) && $stable(devIrqType)));

  // R4
  close_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOpen && ioWr && !portSel && wrData == 8'hAA) |=> !cfgOpen);

  // R2
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgOpen && !(ioWr && !portSel && wrData == 8'hA5)) |=> !cfgOpen);

  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |-> rdData == 8'h00);

endmodule

bind sio_cfg_port sio_cfg_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .portSel(portSel),
  .wrData(wrData), .rdData(rdData), .cfgOpen(cfgOpen), .devEnable(devEnable),
  .devIoBase(devIoBase), .devIrqNum(devIrqNum), .devIrqType(devIrqType)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;

  localparam int ND = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioWr = 1'b0, ioRd = 1'b0, portSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic cfgOpen;
  logic [ND-1:0] devEnable;
  logic [ND*16-1:0] devIoBase;
  logic [ND*8-1:0] devIrqNum, devIrqType;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .portSel(portSel),
    .wrData(wrData), .rdData(rdData), .cfgOpen(cfgOpen), .devEnable(devEnable),
    .devIoBase(devIoBase), .devIrqNum(devIrqNum), .devIrqType(devIrqType)
  );

  // reference model: 0 closed, 1 one key seen, 2 open
  int mKey;
  int mIdx, mLdn;
  int mEn[ND], mBase[ND], mIrq[ND], mTyp[ND];

  function automatic int slotOf(int ldn);
    if (ldn == 8'h02) return 0;
    if (ldn == 8'h0D) return 1;
    return -1;
  endfunction

  function automatic int expRead();
    int s;
    if (!ioRd) return 0;
    if (mKey != 2) return 8'hFF;
    if (!portSel) return mIdx;
    if (mIdx == 8'h07) return mLdn;
    s = slotOf(mLdn);
    if (s < 0) return 0;
    case (mIdx)
      8'h30: return mEn[s];
      8'h60: return mBase[s] >> 8;
      8'h61: return mBase[s] & 8'hFF;
      8'h70: return mIrq[s];
      8'h71: return mTyp[s];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mKey = 0; mIdx = 0; mLdn = 0;
      for (int k = 0; k < ND; k++) begin
        mEn[k] = 0; mBase[k] = 0; mIrq[k] = 0; mTyp[k] = 0;
      end
    end else if (ioWr && !portSel) begin
      if (mKey == 0) mKey = (wrData == 8'hA5) ? 1 : 0;
      else if (mKey == 1) mKey = (wrData == 8'hA5) ? 2 : 0;
      else if (wrData == 8'hAA) mKey = 0;
      else mIdx = wrData;
    end else if (ioWr && portSel && mKey == 2) begin
      int s;
      s = slotOf(mLdn);
      if (mIdx == 8'h07) mLdn = wrData;
      else if (s >= 0) begin
        case (mIdx)
          8'h30: mEn[s] = wrData[0];
          8'h60: mBase[s] = (mBase[s] & 8'hFF) | (int'(wrData) << 8);
          8'h61: mBase[s] = (mBase[s] & 16'hFF00) | int'(wrData);
          8'h70: mIrq[s] = wrData;
          8'h71: mTyp[s] = wrData;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (int'(rdData) != expRead()) begin
        failures++;
        $display("FAIL %s rdData actual=%02h expected=%02h", curReq, rdData, expRead());
      end
      checks++;
      if (cfgOpen != (mKey == 2)) begin
        failures++;
        $display("FAIL %s cfgOpen actual=%0d expected=%0d", curReq, cfgOpen, mKey == 2);
      end
      for (int k = 0; k < ND; k++) begin
        checks++;
        if (devEnable[k] != mEn[k][0] || int'(devIoBase[k*16 +: 16]) != mBase[k] ||
            int'(devIrqNum[k*8 +: 8]) != mIrq[k] || int'(devIrqType[k*8 +: 8]) != mTyp[k]) begin
          failures++;
          $display("FAIL %s slot%0d actual=%0d/%04h/%02h/%02h expected=%0d/%04h/%02h/%02h",
                   curReq, k, devEnable[k], devIoBase[k*16 +: 16], devIrqNum[k*8 +: 8],
                   devIrqType[k*8 +: 8], mEn[k], mBase[k], mIrq[k], mTyp[k]);
        end
      end
    end
  end

  task automatic drive(input logic wr, input logic rd, input logic sel, input logic [7:0] d);
    @(posedge clk);
    #2;
    ioWr = wr; ioRd = rd; portSel = sel; wrData = d;
  endtask

  task automatic idxW(input logic [7:0] d);
    drive(1'b1, 1'b0, 1'b0, d);
  endtask

  task automatic datW(input logic [7:0] d);
    drive(1'b1, 1'b0, 1'b1, d);
  endtask

  task automatic expectRd(input logic sel, input logic [7:0] exp, input string req);
    drive(1'b0, 1'b1, sel, 8'h00);
    @(negedge clk);
    #1;
    checks++;
    if (rdData !== exp) begin
      failures++;
      $display("FAIL %s read port%0d actual=%02h expected=%02h", req, sel, rdData, exp);
    end
  endtask

  task automatic expectVal(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setReg(input logic [7:0] r, input logic [7:0] v);
    idxW(r);
    datW(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    curReq = "R1";
    expectVal(cfgOpen, 0, "R1 open");
    expectVal(devIoBase, 0, "R1 base");
    expectVal(devEnable, 0, "R1 enable");

    // R3 closed space
    curReq = "R3";
    setReg(8'h07, 8'h02);
    setReg(8'h60, 8'h55);
    expectRd(1'b1, 8'hFF, "R3");
    expectRd(1'b0, 8'hFF, "R3");
    expectVal(devIoBase, 0, "R3 base");

    // R2 interrupted key
    curReq = "R2";
    idxW(8'hA5); idxW(8'h10); idxW(8'hA5);
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    expectVal(cfgOpen, 0, "R2 interrupted");
    idxW(8'hA5);
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    expectVal(cfgOpen, 1, "R2 open");

    // R5 index readback
    curReq = "R5";
    idxW(8'h3C);
    expectRd(1'b0, 8'h3C, "R5");

    // R6 device number
    curReq = "R6";
    setReg(8'h07, 8'h02);
    expectRd(1'b1, 8'h02, "R6");

    // R7 program slot 0
    curReq = "R7";
    setReg(8'h30, 8'hFF);
    expectRd(1'b1, 8'h01, "R7 enable mask");
    setReg(8'h60, 8'h03);
    setReg(8'h61, 8'hF8);
    setReg(8'h70, 8'h04);
    setReg(8'h71, 8'h01);
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    expectVal(devIoBase[15:0], 16'h03F8, "R7 base");
    expectVal(devIrqNum[7:0], 8'h04, "R7 irq");
    expectVal(devIrqType[7:0], 8'h01, "R7 type");
    expectVal(devEnable[0], 1, "R7 enable");
    idxW(8'h71);
    expectRd(1'b1, 8'h01, "R7 type read");

    // R8 slot 1 is separate
    curReq = "R8";
    setReg(8'h07, 8'h0D);
    setReg(8'h60, 8'h12);
    setReg(8'h61, 8'h34);
    setReg(8'h30, 8'h01);
    idxW(8'h60);
    expectRd(1'b1, 8'h12, "R8 slot1");
    expectVal(devIoBase[31:16], 16'h1234, "R8 slot1 base");
    expectVal(devIoBase[15:0], 16'h03F8, "R8 slot0 kept");
    setReg(8'h07, 8'h02);
    idxW(8'h61);
    expectRd(1'b1, 8'hF8, "R8 slot0 read");

    // R9 unknown device number
    curReq = "R9";
    setReg(8'h07, 8'h05);
    setReg(8'h70, 8'h77);
    expectRd(1'b1, 8'h00, "R9");
    expectVal(devIrqNum, 16'h0004, "R9 no write");

    // R10 undefined registers
    curReq = "R10";
    setReg(8'h07, 8'h02);
    setReg(8'h20, 8'h99);
    expectRd(1'b1, 8'h00, "R10 0x20");
    setReg(8'h45, 8'h66);
    expectRd(1'b1, 8'h00, "R10 0x45");

    // R11 idle read
    curReq = "R11";
    drive(1'b0, 1'b0, 1'b1, 8'h00);
    @(negedge clk);
    expectVal(rdData, 0, "R11");

    // R4 close
    curReq = "R4";
    idxW(8'hAA);
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    expectVal(cfgOpen, 0, "R4");
    setReg(8'h60, 8'hEE);
    expectRd(1'b1, 8'hFF, "R4 closed read");
    expectVal(devIoBase[15:0], 16'h03F8, "R4 write ignored");

    drive(1'b0, 1'b0, 1'b0, 8'h00);
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule